// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers interrupt requests from the memory-mapped peripherals of a small processor system (the general-purpose I/O ports and the serial port) and presents one interrupt request line to the CPU. Each incoming request pulse is latched into a sticky status bit. An enable register masks the status bits. The OR of the unmasked bits drives the CPU request line through a register.

Software sees four word registers in a 16-byte window. A read-only view shows the latched status. A read/write register holds one enable bit per source. A read-only view shows the masked (pending) bits. A write-only register acknowledges sources: each 1 written clears the matching status bit. The CPU's trap logic decides which pending source to serve, in what order, and where to vector. The aggregator only collects, masks and acknowledges.

The register bus is a single-cycle select/write strobe. Read data is registered and appears in the cycle after the read.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, the status bits, the enable bits, `bus_rdata` and `cpu_irq` are all 0.
- R2: Status bit positions are fixed. GPIO port k drives bit k for k = 0..3, the serial receive request drives bit 4, and the serial transmit request drives bit 5. A request that is high in a cycle sets its bit, and the bit stays set until software clears it.
- R3: The enable register sits at byte offset 0x4. It is read/write. Only bits 5:0 are stored, and bits 31:6 always read 0.
- R4: The status view at offset 0x0 returns the latched status bits. The pending view at offset 0x8 returns status AND enable. Bits 31:6 of both read 0.
- R5: A write to the clear register at offset 0xC clears each status bit whose data bit is 1. Bits written as 0 leave their status bits unchanged.
- R6: If a request sets a status bit in the same cycle that a clear write targets it, the bit ends up set.
- R7: `cpu_irq` goes high one cycle after any pending bit is 1. It goes low one cycle after no pending bit is 1.
- R8: Writes to offsets 0x0 and 0x8 change nothing. A read of offset 0xC returns 0.
- R9: An access hits the window only when address bits 7:4 are zero and bits 1:0 are zero. Any other access reads 0 and writes nothing.
- R10: `bus_rdata` carries the read value in the cycle after a read access. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, valid with `bus_sel` |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gpio_irq | input | 4 | Request from each GPIO port |
| uart_rx_irq | input | 1 | Serial receive request |
| uart_tx_irq | input | 1 | Serial transmit request |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Two functions can fall in the same cycle: a peripheral request setting a status bit and a software acknowledge clearing it. The bench first loads a known status pattern. It then issues a clear write with many masks while, on that same clock edge, it drives request patterns that partly overlap the mask. A status read afterwards must equal the old status with the masked bits removed, ORed with the new requests. Beyond that, the bench sweeps all 64 status patterns against all 64 enable patterns and compares the pending view and the request line with the bitwise AND computed in the bench.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [2:0] {
    REG_NONE    = 3'd0,
    REG_STATUS  = 3'd1,
    REG_ENABLE  = 3'd2,
    REG_PENDING = 3'd3,
    REG_CLEAR   = 3'd4
  } reg_sel_e;

  localparam int WINDOW_BITS = 4;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel_o
);

  logic in_window;

  always_comb begin
    in_window = bus_sel
             && (bus_addr[1:0] == 2'b00)
             && (bus_addr[ADDR_W-1:WINDOW_BITS] == '0);
  end

  always_comb begin
    sel_o = REG_NONE;
    if (in_window) begin
      case (bus_addr[3:2])
        2'd0:    sel_o = REG_STATUS;
        2'd1:    sel_o = REG_ENABLE;
        2'd2:    sel_o = REG_PENDING;
        2'd3:    sel_o = REG_CLEAR;
        default: sel_o = REG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_wr_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] status_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= 1'b0;
      end else if (set_i[i]) begin
        bit_q <= 1'b1;
      end else if (clr_wr_i && clr_mask_i[i]) begin
        bit_q <= 1'b0;
      end
    end

    assign status_o[i] = bit_q;

    // R6: a request wins over a same-cycle acknowledge
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> status_o[i]);

    // R2: a latched bit holds while no acknowledge targets it
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      (status_o[i] && !(clr_wr_i && clr_mask_i[i])) |=> status_o[i]);

    // R5: an acknowledge without a competing request empties the bit
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_wr_i && clr_mask_i[i] && !set_i[i]) |=> !status_o[i]);
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] enable_o
);

  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q <= wdata_i;
    end
  end

  assign enable_o = en_q;

  // R3: a write lands in the register on the next edge
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (enable_o == $past(wdata_i)));

  // R3: without a write the register holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(enable_o));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_i,
  input  reg_sel_e           sel_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  output logic [DATA_W-1:0]  rdata_o
);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] pick;
  logic [DATA_W-1:0]  pick_ext;
  logic [DATA_W-1:0]  rdata_q;

  always_comb begin
    pend = status_i & enable_i;
    case (sel_i)
      REG_STATUS:  pick = status_i;
      REG_ENABLE:  pick = enable_i;
      REG_PENDING: pick = pend;
      default:     pick = '0;
    endcase
    pick_ext = '0;
    pick_ext[NUM_SRC-1:0] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= pick_ext;
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  // R10: read data is zero in every cycle that does not follow a read
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_o == '0));

  // R8: the acknowledge register reads back as zero
  a_r8_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == REG_CLEAR) |=> (rdata_o == '0));

  // R9: a missed access returns zero
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i == REG_NONE) |=> (rdata_o == '0));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int GPIO_PORTS = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [GPIO_PORTS-1:0] gpio_irq,
  input  logic                  uart_rx_irq,
  input  logic                  uart_tx_irq,
  output logic                  cpu_irq
);

  localparam int NUM_SRC = GPIO_PORTS + 2;

  reg_sel_e           sel;
  logic               en_wr;
  logic               clr_wr;
  logic               rd;
  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable;
  logic               irq_q;

  if (DATA_W > NUM_SRC) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
  end

  always_comb begin
    src_vec = {uart_tx_irq, uart_rx_irq, gpio_irq};
    en_wr   = bus_sel && bus_wr && (sel == REG_ENABLE);
    clr_wr  = bus_sel && bus_wr && (sel == REG_CLEAR);
    rd      = bus_sel && !bus_wr;
  end

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .sel_o    (sel)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .set_i      (src_vec),
    .clr_wr_i   (clr_wr),
    .clr_mask_i (bus_wdata[NUM_SRC-1:0]),
    .status_o   (status)
  );

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (en_wr),
    .wdata_i  (bus_wdata[NUM_SRC-1:0]),
    .enable_o (enable)
  );

  irq_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (rd),
    .sel_i    (sel),
    .status_i (status),
    .enable_i (enable),
    .rdata_o  (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(status & enable);
    end
  end

  assign cpu_irq = irq_q;

  // R7: the request line follows the pending bits one cycle later
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(status & enable)) |=> cpu_irq);

  a_r7_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(status & enable)) |=> !cpu_irq);

  // R8: writes to the read-only views leave the status bits untouched
  a_r8_ro_write: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && (sel == REG_STATUS || sel == REG_PENDING) && src_vec == '0)
      |=> $stable(status));

  // R9: a missed write alters no register
  a_r9_miss_write: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && sel == REG_NONE && src_vec == '0)
      |=> ($stable(status) && $stable(enable)));

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  gpio_irq = '0;
  logic        uart_rx_irq = 1'b0;
  logic        uart_tx_irq = 1'b0;
  logic        cpu_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator u0 (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .gpio_irq, .uart_rx_irq, .uart_tx_irq, .cpu_irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive_src(input logic [5:0] s);
    gpio_irq = s[3:0]; uart_rx_irq = s[4]; uart_tx_irq = s[5];
  endtask

  task automatic pulse(input logic [5:0] s);
    @(negedge clk);
    drive_src(s);
    @(negedge clk);
    drive_src(6'd0);
  endtask

  task automatic clear_with_pulse(input logic [5:0] c, input logic [5:0] p);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = {26'd0, c};
    drive_src(p);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    drive_src(6'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    bus_read(8'h00, rv); chk("R1 status", rv, 32'd0);
    bus_read(8'h04, rv); chk("R1 enable", rv, 32'd0);

    // R3: only low six bits stored
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, rv); chk("R3 enable width", rv, 32'h3F);
    bus_write(8'h04, 32'hA5A5_A512);
    bus_read(8'h04, rv); chk("R3 enable value", rv, 32'h12);

    // R7: latency of the request line
    bus_write(8'h04, 32'h3F);
    @(negedge clk);
    drive_src(6'b000100);
    @(negedge clk);
    drive_src(6'd0);
    chk("R7 not yet", {31'd0, cpu_irq}, 32'd0);
    @(negedge clk);
    chk("R7 raised", {31'd0, cpu_irq}, 32'd1);
    bus_write(8'h0C, 32'h3F);
    chk("R7 still high one cycle", {31'd0, cpu_irq}, 32'd1);
    @(negedge clk);
    chk("R7 dropped", {31'd0, cpu_irq}, 32'd0);

    // R2 R4 R7: exhaustive status x enable sweep
    for (int s = 0; s < 64; s++) begin
      for (int e = 0; e < 64; e++) begin
        bus_write(8'h04, e);
        pulse(s[5:0]);
        bus_read(8'h08, rv); chk("R4 pending", rv, s & e);
        chk("R7 irq", {31'd0, cpu_irq}, {31'd0, (s & e) != 0});
        bus_read(8'h00, rv); chk("R2 status", rv, s);
        bus_write(8'h0C, 32'hFFFF_FFFF);
      end
    end
    bus_read(8'h00, rv); chk("R5 all cleared", rv, 32'd0);

    // R2: sticky after the request ends, with individual source mapping
    pulse(6'b010000);
    repeat (3) @(negedge clk);
    bus_read(8'h00, rv); chk("R2 rx on bit 4 sticky", rv, 32'h10);
    pulse(6'b100000);
    bus_read(8'h00, rv); chk("R2 tx on bit 5", rv, 32'h30);

    // R5: partial clear
    bus_write(8'h0C, 32'h10);
    bus_read(8'h00, rv); chk("R5 partial clear", rv, 32'h20);
    bus_write(8'h0C, 32'h0);
    bus_read(8'h00, rv); chk("R5 zero write keeps", rv, 32'h20);
    bus_write(8'h0C, 32'h3F);

    // R6: same-cycle request and acknowledge
    for (int c = 0; c < 64; c++) begin
      logic [5:0] p;
      p = 6'(c * 5 + 3);
      pulse(6'h3F);
      clear_with_pulse(c[5:0], p);
      bus_read(8'h00, rv);
      chk("R6 set wins", rv, {26'd0, (6'h3F & ~c[5:0]) | p});
      bus_write(8'h0C, 32'h3F);
    end

    // R8: read-only views ignore writes, clear reads zero
    bus_write(8'h04, 32'h0F);
    pulse(6'b001010);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, rv); chk("R8 status write ignored", rv, 32'h0A);
    bus_write(8'h08, 32'h3F);
    bus_read(8'h08, rv); chk("R8 pending write ignored", rv, 32'h0A);
    bus_read(8'h04, rv); chk("R8 enable unchanged", rv, 32'h0F);
    bus_read(8'h0C, rv); chk("R8 clear reads zero", rv, 32'd0);

    // R9: accesses outside the window or misaligned
    bus_read(8'h10, rv); chk("R9 out of window read", rv, 32'd0);
    bus_read(8'h05, rv); chk("R9 misaligned read", rv, 32'd0);
    bus_write(8'h14, 32'h30);
    bus_read(8'h04, rv); chk("R9 out of window write", rv, 32'h0F);
    bus_write(8'h1C, 32'h3F);
    bus_write(8'h0D, 32'h3F);
    bus_read(8'h00, rv); chk("R9 misaligned clear ignored", rv, 32'h0A);

    // R10: read data returns to zero when idle
    @(negedge clk);
    chk("R10 idle zero", bus_rdata, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule